// File: doc/BRIEF.md
# Edge-Selectable 16-bit GPIO Port

This block is a sixteen-line general-purpose I/O port controlled through a small register bus of 16-bit words. Each line can be an input or an output. Output lines drive the value held in an output latch. Input lines pass through a two-flop synchroniser. A transition on an input line that matches the polarity chosen for that line, and that is not blocked by the line's mask bit, sets a sticky status bit. Any set status bit raises a single interrupt request. Software clears status bits by writing ones to them.

The sampled input word can be read back through a pin-enable filter, which is ANDed with the synchronised inputs. The bus side is a small state machine with two states. In `BUS_IDLE` no read result is pending. In `BUS_RESP` the read data is presented with `bus_rvalid` high. A read request in either state moves the machine to `BUS_RESP` for the next cycle (transition READ_ACCEPT). A cycle with no read request returns it to `BUS_IDLE` (transition RESP_DONE). Writes complete in the cycle they are presented and do not change the state.

Register offsets (byte addresses; a read or write takes effect only if the lowest two address bits are zero):

| Offset | Register |
|---|---|
| 0x00 | input word (read-only) |
| 0x04 | output latch |
| 0x08 | direction |
| 0x0C | edge polarity |
| 0x10 | interrupt mask |
| 0x14 | interrupt status |
| 0x18 | pin enable |

Top module: `gpio16_port`

## Requirements
- R1: After reset, the output latch, direction, edge polarity, mask and pin-enable registers read 0xFFFF. The status register and the input word read 0x0000. `pin_oe`, `pin_out` and `irq` are 0.
- R2: A direction bit of 0 makes the line an output: `pin_oe` is high for that line and `pin_out` shows the output-latch bit. A direction bit of 1 makes the line an input: `pin_oe` is low and `pin_out` is 0.
- R3: Reading offset 0x00 returns the inputs after the two-flop synchroniser, ANDed with the pin-enable register at 0x18.
- R4: An edge-polarity bit of 1 selects rising edges and 0 selects falling edges. The opposite edge sets nothing. A qualifying input change driven before clock edge k sets its status bit, and raises `irq`, at edge k+2. At edge k+1 nothing is set yet.
- R5: A line whose mask bit is 1 sets no status bit, and neither does a line whose direction bit is 0.
- R6: Writing 0x14 clears each status bit written as 1 and leaves the other bits unchanged. `irq` is high exactly while at least one status bit is set.
- R7: If a new event on a line and a write clearing that line's status bit arrive in the same cycle, the status bit ends up set.
- R8: An access with `bus_full` low changes no register, and a read of that kind returns 0x0000.
- R9: Writes to offset 0x00 and to unmapped or misaligned offsets are ignored. Reads of unmapped or misaligned offsets return 0x0000.
- R10: Each read request gives exactly one response: `bus_rvalid` is high, with the data on `bus_rdata`, in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_full | input | 1 | 1 = full 16-bit access, 0 = narrower access |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe |
| pin_in | input | 16 | Asynchronous line inputs |
| pin_out | output | 16 | Driven line values |
| pin_oe | output | 16 | Per-line output enable |
| pin_in is sampled even on output lines; pin_out is 0 on input lines | | | |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted direction or output-latch bit shows on `pin_oe` or `pin_out` in the cycle after the offending write. A synchroniser or edge-detector fault shows up as `irq` and status rising one cycle early, one cycle late, on the wrong polarity or on a masked line, all within three clocks of the pin change. A fault in the status clear or in its priority over new events appears as `irq` staying high or dropping in the cycle after the status write. A fault in the bus state machine appears as a missing, duplicated or mistimed `bus_rvalid` on the very next cycle.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;

    localparam int GP_W   = 16;
    localparam int IDX_W  = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_IN   = 3'd0,
        IDX_OUT  = 3'd1,
        IDX_DIR  = 3'd2,
        IDX_EDGE = 3'd3,
        IDX_MASK = 3'd4,
        IDX_STAT = 3'd5,
        IDX_PINS = 3'd6,
        IDX_NONE = 3'd7
    } reg_idx_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic [GP_W-1:0] out_data;
        logic [GP_W-1:0] dir;
        logic [GP_W-1:0] edge_sel;
        logic [GP_W-1:0] mask;
        logic [GP_W-1:0] pin_en;
    } port_cfg_t;

endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] last
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            last_q <= '0;
        end else begin
            meta_q <= raw;
            cur_q  <= meta_q;
            last_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign last = last_q;
endmodule

// File: rtl/gpio16_detect.sv
module gpio16_detect #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] last,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] mask,
    output logic [W-1:0] evt
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic rise;
        logic fall;
        assign rise   = cur[i] & ~last[i];
        assign fall   = ~cur[i] & last[i];
        assign evt[i] = dir[i] & ~mask[i] & (edge_sel[i] ? rise : fall);
    end
endmodule

// File: rtl/gpio16_regs.sv
module gpio16_regs
    import gpio16_pkg::*;
#(
    parameter int W = GP_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  reg_idx_e   idx,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] sample,
    output port_cfg_t  cfg,
    output logic [W-1:0] status,
    output logic [W-1:0] rd_word
);
    port_cfg_t    cfg_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] clr;

    assign clr = (wr_en && idx == IDX_STAT) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '1;
            stat_q <= '0;
        end else begin
            // a new event outranks a clear of the same bit
            stat_q <= (stat_q & ~clr) | evt;
            if (wr_en) begin
                case (idx)
                    IDX_OUT:  cfg_q.out_data <= wdata;
                    IDX_DIR:  cfg_q.dir      <= wdata;
                    IDX_EDGE: cfg_q.edge_sel <= wdata;
                    IDX_MASK: cfg_q.mask     <= wdata;
                    IDX_PINS: cfg_q.pin_en   <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (idx)
            IDX_IN:   rd_word = sample & cfg_q.pin_en;
            IDX_OUT:  rd_word = cfg_q.out_data;
            IDX_DIR:  rd_word = cfg_q.dir;
            IDX_EDGE: rd_word = cfg_q.edge_sel;
            IDX_MASK: rd_word = cfg_q.mask;
            IDX_STAT: rd_word = stat_q;
            IDX_PINS: rd_word = cfg_q.pin_en;
            default:  rd_word = '0;
        endcase
    end

    assign cfg    = cfg_q;
    assign status = stat_q;
endmodule

// File: rtl/gpio16_port.sv
module gpio16_port
    import gpio16_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_full,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GP_W-1:0]   bus_wdata,
    output logic [GP_W-1:0]   bus_rdata,
    output logic              bus_rvalid,
    input  logic [GP_W-1:0]   pin_in,
    output logic [GP_W-1:0]   pin_out,
    output logic [GP_W-1:0]   pin_oe,
    output logic              irq
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    reg_idx_e      idx;
    logic          wr_en;
    logic          rd_req;
    logic [GP_W-1:0] cur;
    logic [GP_W-1:0] last;
    logic [GP_W-1:0] evt;
    logic [GP_W-1:0] status_q;
    logic [GP_W-1:0] rd_word;
    logic [GP_W-1:0] rdata_q;
    port_cfg_t     cfg_q;
    bus_state_e    state_q;
    bus_state_e    state_d;

    always_comb begin
        if (bus_addr[IDX_LO-1:0] == '0 && bus_addr[ADDR_W-1:IDX_HI+1] == '0)
            idx = reg_idx_e'(bus_addr[IDX_HI:IDX_LO]);
        else
            idx = IDX_NONE;
    end

    assign wr_en  = bus_valid & bus_write & bus_full;
    assign rd_req = bus_valid & ~bus_write;

    gpio16_sync #(.W(GP_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pin_in),
        .cur  (cur),
        .last (last)
    );

    gpio16_detect #(.W(GP_W)) u_detect (
        .cur     (cur),
        .last    (last),
        .dir     (cfg_q.dir),
        .edge_sel(cfg_q.edge_sel),
        .mask    (cfg_q.mask),
        .evt     (evt)
    );

    gpio16_regs #(.W(GP_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .idx    (idx),
        .wdata  (bus_wdata),
        .evt    (evt),
        .sample (cur),
        .cfg    (cfg_q),
        .status (status_q),
        .rd_word(rd_word)
    );

    // bus response state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req)
                rdata_q <= bus_full ? rd_word : '0;
        end
    end

    // bus response state machine: outputs
    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            BUS_IDLE: ;
            BUS_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = rdata_q;
            end
        endcase
    end

    assign pin_oe  = ~cfg_q.dir;
    assign pin_out = cfg_q.out_data & ~cfg_q.dir;
    assign irq     = |status_q;
endmodule

// File: rtl/gpio16_port_chk.sv
module gpio16_port_chk #(
    parameter int ADDR_W = 8,
    parameter int W      = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              bus_full,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_rdata,
    input logic              bus_rvalid,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic              irq,
    input logic [W-1:0]      status,
    input logic [W-1:0]      mask
);
    logic rd_req;
    logic wr_stat;
    logic unmapped;

    assign rd_req   = bus_valid && !bus_write;
    assign wr_stat  = bus_valid && bus_write && bus_full && bus_addr == ADDR_W'(8'h14);
    assign unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr[ADDR_W-1:5] != '0)
                      || (bus_addr[4:2] == 3'd7);

    p_resp_follows_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    p_no_stray_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && unmapped) |=> bus_rdata == '0);

    p_narrow_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !bus_full) |=> bus_rdata == '0);

    p_narrow_write_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !bus_full) |=> ($stable(pin_out) && $stable(pin_oe)));

    p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & $past(mask)) == '0));

    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_stat) |=> irq);
endmodule

bind gpio16_port gpio16_port_chk #(.ADDR_W(ADDR_W), .W(gpio16_pkg::GP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_full  (bus_full),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .status    (status_q),
    .mask      (cfg_q.mask)
);

// File: tb/tb_gpio16_port.sv
`timescale 1ns/1ps
module tb_gpio16_port;
    localparam logic [7:0] A_IN = 8'h00, A_OUT = 8'h04, A_DIR = 8'h08, A_EDGE = 8'h0C,
                           A_MASK = 8'h10, A_STAT = 8'h14, A_PINS = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_full = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
    logic        bus_rvalid, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] q_exp[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    gpio16_port dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_full(bus_full), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (q_exp.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R10: actual unexpected response %h expected none", bus_rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                chk(t, bus_rdata, e);
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [15:0] d, input bit full = 1'b1);
        bus_valid = 1'b1; bus_write = 1'b1; bus_full = full; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_full = 1'b1;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [15:0] exp, input string tag,
                          input bit full = 1'b1);
        bus_valid = 1'b1; bus_write = 1'b0; bus_full = full; bus_addr = a;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_full = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 16'h0000);
        chk("R1 pin_out", pin_out, 16'h0000);
        chk("R1 irq", 16'(irq), 16'h0000);
        bus_rd(A_OUT,  16'hFFFF, "R1 out latch");
        bus_rd(A_DIR,  16'hFFFF, "R1 direction");
        bus_rd(A_EDGE, 16'hFFFF, "R1 edge");
        bus_rd(A_MASK, 16'hFFFF, "R1 mask");
        bus_rd(A_PINS, 16'hFFFF, "R1 pin enable");
        bus_rd(A_STAT, 16'h0000, "R1 status");
        bus_rd(A_IN,   16'h0000, "R1 input");

        // R2 outputs on upper byte
        bus_wr(A_DIR, 16'h00FF);
        bus_wr(A_OUT, 16'hA5A5);
        chk("R2 pin_oe", pin_oe, 16'hFF00);
        chk("R2 pin_out", pin_out, 16'hA500);
        bus_rd(A_OUT, 16'hA5A5, "R2 out latch");

        // R3 input gating
        pin_in = 16'h1234;
        idle(3);
        bus_wr(A_PINS, 16'h0F0F);
        bus_rd(A_IN, 16'h0204, "R3 gated input");
        bus_wr(A_PINS, 16'hFFFF);
        bus_rd(A_IN, 16'h1234, "R3 full input");
        pin_in = 16'h0000;
        idle(4);
        bus_rd(A_STAT, 16'h0000, "R5 all masked");

        // R4 rising edge timing
        bus_wr(A_MASK, 16'hFF00);
        bus_wr(A_EDGE, 16'hFFFD);
        pin_in = 16'h0001;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R4 irq not yet", 16'(irq), 16'h0000);
        @(posedge clk); @(negedge clk);
        chk("R4 irq set", 16'(irq), 16'h0001);
        bus_rd(A_STAT, 16'h0001, "R4 rising status");

        // R4 falling-only line
        pin_in = 16'h0003;
        idle(4);
        bus_rd(A_STAT, 16'h0001, "R4 rise ignored on falling line");
        pin_in = 16'h0001;
        idle(4);
        bus_rd(A_STAT, 16'h0003, "R4 falling status");

        // R5 masked line and output line
        bus_wr(A_MASK, 16'hFF04);
        pin_in = 16'h0005;
        idle(4);
        bus_rd(A_STAT, 16'h0003, "R5 masked line");
        bus_wr(A_MASK, 16'h0000);
        pin_in = 16'h0105;
        idle(4);
        bus_rd(A_STAT, 16'h0003, "R5 output line");

        // R6 write-one-to-clear
        bus_wr(A_STAT, 16'h0001);
        chk("R6 irq held", 16'(irq), 16'h0001);
        bus_rd(A_STAT, 16'h0002, "R6 partial clear");
        bus_wr(A_STAT, 16'h0002);
        chk("R6 irq low", 16'(irq), 16'h0000);

        // R7 event beats clear
        pin_in = 16'h0104;
        idle(4);
        bus_rd(A_STAT, 16'h0000, "R7 precondition");
        pin_in = 16'h0105;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_wr(A_STAT, 16'h0001);
        chk("R7 irq", 16'(irq), 16'h0001);
        bus_rd(A_STAT, 16'h0001, "R7 event wins");
        bus_wr(A_STAT, 16'hFFFF);

        // R8 narrow accesses
        bus_wr(A_OUT, 16'h0000, 1'b0);
        chk("R8 pin_out", pin_out, 16'hA500);
        bus_rd(A_OUT, 16'h0000, "R8 narrow read", 1'b0);
        bus_rd(A_OUT, 16'hA5A5, "R8 latch kept");

        // R9 read-only and unmapped
        bus_wr(A_IN, 16'h0000);
        bus_rd(A_IN, 16'h0105, "R9 input write ignored");
        bus_wr(8'h1C, 16'h0000);
        bus_wr(8'h0A, 16'h0000);
        bus_rd(A_DIR, 16'h00FF, "R9 unmapped write ignored");
        bus_rd(8'h1C, 16'h0000, "R9 unmapped read");
        bus_rd(8'h0A, 16'h0000, "R9 misaligned read");

        // R2 direction back to inputs
        bus_wr(A_DIR, 16'hFFFF);
        chk("R2 all inputs oe", pin_oe, 16'h0000);
        chk("R2 all inputs out", pin_out, 16'h0000);

        idle(3);
        chk("R10 responses drained", 16'(q_exp.size()), 16'h0000);
        done = 1'b1;
        finish_run();
    end
endmodule